// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for a small group of pins, parameterised for 8 or 12 pins. Software uses a 32-bit register interface to control each pin. It can drive the pin from an output data bit or leave it as an input, and it can read back the pin level after a two-flop synchronizer. Every pin also has an event detector. The detector can be set to fire on a rising edge, a falling edge, either edge, a high level or a low level.

Detected events are latched into a status word. Each status bit is gated by a per-pin enable and cleared by writing a one. A mask register hides status bits from the interrupt output. It is set through one address and cleared through another, so two agents can change different bits without a read-modify-write. The visible (unmasked) status is ORed into a single interrupt line. A soft reset register holds every other register at its reset value while its bit is 1. A function-select word is stored and read back; nothing else uses it.

Writes take effect at the clock edge on which `wrEn` is high. Reads are combinational from `regAddr`. Word offsets are `regAddr[5:2]`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Register word offsets and reset values:
  - 0x00 enable, reset 0.
  - 0x04 status, reset 0.
  - 0x08 display, reset 0.
  - 0x0C clear, reads 0.
  - 0x10 mask-set and 0x14 mask-clear, both read the mask, which resets to all pins masked.
  - 0x18 output data, reset 0.
  - 0x1C input level.
  - 0x20 direction, reset 0.
  - 0x24 mode word 0 and 0x28 mode word 1, both reset 0.
  - 0x38 function select, reset 0.
  - 0x3C soft reset, bit 0, reset 0.
  - Offsets 0x2C to 0x34 read 0 and ignore writes.
- R2: In every per-pin register, bits at or above the pin count read 0 and ignore writes.
- R3: `pinOe` equals the direction register, where 1 means output. `pinOut` equals the output data register.
- R4: Offset 0x1C returns `pinIn` delayed through a two-flop synchronizer. A change applied before clock edge k reads back after edge k+1. Writes to 0x1C, 0x04 and 0x08 have no effect.
- R5: The trigger mode of pin n is a 3-bit field at bit 4·n of mode word 0 for n<8, and at bit 4·(n−8) of mode word 1 for n≥8. Other bits read 0. Codes: 0 falling, 1 rising, 2 level low, 3 level high, 4 both edges; 5, 6 and 7 never trigger.
- R6: A status bit sets only while its enable bit is 1 and its trigger condition is present. Edges are judged on the synchronized level. Status stays set until cleared.
- R7: When a trigger and a clear of the same bit coincide, the bit stays set. A level trigger therefore re-sets its bit while the level persists.
- R8: Writing 1 to a bit at 0x10 masks that pin, and writing 1 at 0x14 unmasks it. Zero bits leave the mask unchanged.
- R9: Writing 1 to a bit at 0x0C clears that status bit. Zero bits leave status unchanged.
- R10: Display (0x08) reads status AND NOT mask. `irqOut` is high exactly when any display bit is 1.
- R11: Writing 1 to the soft reset register holds all other registers at their reset values and ignores writes to them. Writing 0 releases them.
- R12: The function-select register stores the written pin bits and reads them back. It has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Byte address of the register, word aligned |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| pinIn | input | PINS | Pin levels from the pads |
| pinOut | output | PINS | Output data to the pads |
| pinOe | output | PINS | Output enable to the pads, 1 = drive |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume a full-word interface: every write is one cycle wide and word aligned, and the address is stable while read data is sampled. They also assume `pinIn` changes no faster than the synchronizer can resolve. The bench drives address, data and pins only on the falling clock edge. It holds each pin level for several cycles, so every edge or level reaches status before the bench reads it. The sweep covers each pin against all eight mode codes, with every other pin parked on a never-triggering code so that no stray status bit appears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned MODE_STRIDE = 4;
  localparam int unsigned PINS_PER_MODE = DATA_W / MODE_STRIDE;

  typedef enum logic [SEL_W-1:0] {
    REG_ENABLE  = 4'h0,
    REG_STATUS  = 4'h1,
    REG_DISPLAY = 4'h2,
    REG_CLEAR   = 4'h3,
    REG_MASKSET = 4'h4,
    REG_MASKCLR = 4'h5,
    REG_OUT     = 4'h6,
    REG_IN      = 4'h7,
    REG_DIR     = 4'h8,
    REG_MODE0   = 4'h9,
    REG_MODE1   = 4'hA,
    REG_FUNC    = 4'hE,
    REG_SRST    = 4'hF
  } regSel_e;

  typedef enum logic [MODE_W-1:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic holdReset;
    logic wrEnable;
    logic wrClear;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrOut;
    logic wrDir;
    logic wrMode0;
    logic wrMode1;
    logic wrFunc;
  } strobe_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              wrBit0,
  output strobe_t           strb,
  output logic [SEL_W-1:0]  rdSel,
  output logic              softRstQ
);

  logic [SEL_W-1:0] wordSel;
  logic             wrGo;
  logic             unusedLowAddr;

  assign wordSel       = regAddr[SEL_LSB +: SEL_W];
  assign unusedLowAddr = ^regAddr[SEL_LSB-1:0];
  assign rdSel         = wordSel;

  // soft reset bit: itself always writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRstQ <= 1'b0;
    end else if (wrEn && wordSel == REG_SRST) begin
      softRstQ <= wrBit0;
    end
  end

  assign wrGo = wrEn && !softRstQ;

  always_comb begin
    strb           = '0;
    strb.holdReset = softRstQ;
    strb.wrEnable  = wrGo && (wordSel == REG_ENABLE);
    strb.wrClear   = wrGo && (wordSel == REG_CLEAR);
    strb.wrMaskSet = wrGo && (wordSel == REG_MASKSET);
    strb.wrMaskClr = wrGo && (wordSel == REG_MASKCLR);
    strb.wrOut     = wrGo && (wordSel == REG_OUT);
    strb.wrDir     = wrGo && (wordSel == REG_DIR);
    strb.wrMode0   = wrGo && (wordSel == REG_MODE0);
    strb.wrMode1   = wrGo && (wordSel == REG_MODE1);
    strb.wrFunc    = wrGo && (wordSel == REG_FUNC);
  end

endmodule

// File: rtl/gpio_irq_pin_detect.sv
module gpio_irq_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinRaw,
  input  logic [MODE_W-1:0] mode,
  output logic              level,
  output logic              hit
);

  logic syncA;
  logic syncB;
  logic prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign level = syncB;

  always_comb begin
    case (mode)
      TRIG_FALL: hit = prevB & ~syncB;
      TRIG_RISE: hit = syncB & ~prevB;
      TRIG_LOW:  hit = ~syncB;
      TRIG_HIGH: hit = syncB;
      TRIG_BOTH: hit = syncB ^ prevB;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic              softRstQ,
  input  logic [PINS-1:0]   pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PINS-1:0]   statusVec,
  output logic [PINS-1:0]   maskVec
);

  localparam int unsigned SLOTS = 2 * PINS_PER_MODE;
  localparam int unsigned PAD_W = DATA_W - PINS;
  localparam logic [PINS-1:0] ALL_PINS = '1;

  logic [PINS-1:0] enQ;
  logic [PINS-1:0] statusQ;
  logic [PINS-1:0] maskQ;
  logic [PINS-1:0] outQ;
  logic [PINS-1:0] dirQ;
  logic [PINS-1:0] funcQ;
  logic [PINS-1:0] levelVec;
  logic [PINS-1:0] hitVec;
  logic [PINS-1:0] pinData;
  logic [PINS-1:0] clrBits;
  logic [PINS-1:0][MODE_W-1:0] modeQ;
  logic [PINS-1:0][MODE_W-1:0] modeSlice;
  logic [PINS-1:0] modeWr;
  logic [DATA_W-1:0] mode0Word;
  logic [DATA_W-1:0] mode1Word;
  logic unusedData;

  assign pinData    = wrData[PINS-1:0];
  assign unusedData = ^wrData;

  // per-pin detection, mode write slicing and mode readback
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [MODE_STRIDE-1:0] nib;
    if (s < PINS) begin : g_pin
      gpio_irq_pin_detect det_i (
        .clk    (clk),
        .rstN   (rstN),
        .pinRaw (pinIn[s]),
        .mode   (modeQ[s]),
        .level  (levelVec[s]),
        .hit    (hitVec[s])
      );
      if (s < PINS_PER_MODE) begin : g_lo
        assign modeWr[s]    = strb.wrMode0;
        assign modeSlice[s] = wrData[MODE_STRIDE*s +: MODE_W];
      end else begin : g_hi
        assign modeWr[s]    = strb.wrMode1;
        assign modeSlice[s] = wrData[MODE_STRIDE*(s-PINS_PER_MODE) +: MODE_W];
      end
      assign nib = {1'b0, modeQ[s]};
    end else begin : g_none
      assign nib = '0;
    end
    if (s < PINS_PER_MODE) begin : g_rd0
      assign mode0Word[MODE_STRIDE*s +: MODE_STRIDE] = nib;
    end else begin : g_rd1
      assign mode1Word[MODE_STRIDE*(s-PINS_PER_MODE) +: MODE_STRIDE] = nib;
    end
  end

  assign clrBits = strb.wrClear ? pinData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      statusQ <= '0;
      maskQ   <= ALL_PINS;
      outQ    <= '0;
      dirQ    <= '0;
      funcQ   <= '0;
      modeQ   <= '0;
    end else if (strb.holdReset) begin
      enQ     <= '0;
      statusQ <= '0;
      maskQ   <= ALL_PINS;
      outQ    <= '0;
      dirQ    <= '0;
      funcQ   <= '0;
      modeQ   <= '0;
    end else begin
      if (strb.wrEnable) enQ <= pinData;
      if (strb.wrOut)    outQ <= pinData;
      if (strb.wrDir)    dirQ <= pinData;
      if (strb.wrFunc)   funcQ <= pinData;
      // new event wins over a coincident clear
      statusQ <= (statusQ & ~clrBits) | (hitVec & enQ);
      maskQ   <= (maskQ | (strb.wrMaskSet ? pinData : '0))
               & ~(strb.wrMaskClr ? pinData : '0);
      for (int n = 0; n < PINS; n++) begin
        if (modeWr[n]) modeQ[n] <= modeSlice[n];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      REG_ENABLE:  rdData = {{PAD_W{1'b0}}, enQ};
      REG_STATUS:  rdData = {{PAD_W{1'b0}}, statusQ};
      REG_DISPLAY: rdData = {{PAD_W{1'b0}}, statusQ & ~maskQ};
      REG_MASKSET,
      REG_MASKCLR: rdData = {{PAD_W{1'b0}}, maskQ};
      REG_OUT:     rdData = {{PAD_W{1'b0}}, outQ};
      REG_IN:      rdData = {{PAD_W{1'b0}}, levelVec};
      REG_DIR:     rdData = {{PAD_W{1'b0}}, dirQ};
      REG_MODE0:   rdData = mode0Word;
      REG_MODE1:   rdData = mode1Word;
      REG_FUNC:    rdData = {{PAD_W{1'b0}}, funcQ};
      REG_SRST:    rdData = {{(DATA_W-1){1'b0}}, softRstQ};
      default:     rdData = '0;
    endcase
  end

  assign pinOut    = outQ;
  assign pinOe     = dirQ;
  assign statusVec = statusQ;
  assign maskVec   = maskQ;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);

  strobe_t          strb;
  logic [SEL_W-1:0] rdSel;
  logic             softRstQ;
  logic [PINS-1:0]  statusVec;
  logic [PINS-1:0]  maskVec;

  gpio_irq_decode ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .wrEn     (wrEn),
    .wrBit0   (wrData[0]),
    .strb     (strb),
    .rdSel    (rdSel),
    .softRstQ (softRstQ)
  );

  gpio_irq_datapath #(.PINS(PINS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .softRstQ  (softRstQ),
    .pinIn     (pinIn),
    .rdData    (rdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .statusVec (statusVec),
    .maskVec   (maskVec)
  );

  assign irqOut = |(statusVec & ~maskVec);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic [PINS-1:0]   pinOe,
  input logic              irqOut,
  input logic              softRstQ,
  input logic [PINS-1:0]   statusVec,
  input logic [PINS-1:0]   maskVec
);

  logic [SEL_W-1:0] sel;
  assign sel = regAddr[SEL_LSB +: SEL_W];

  // R9
  status_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusVec) & ~statusVec)) |->
      ($past(wrEn && sel == REG_CLEAR && !softRstQ) || $past(softRstQ)));

  // R8
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(~$past(maskVec) & maskVec)) |->
      ($past(wrEn && sel == REG_MASKSET && !softRstQ) || $past(softRstQ)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|statusVec));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel != REG_MODE0 && sel != REG_MODE1) |-> (rdData[DATA_W-1:PINS] == '0));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOe) |->
      ($past(wrEn && sel == REG_DIR && !softRstQ) || $past(softRstQ)));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PINS(PINS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .wrEn      (wrEn),
  .rdData    (rdData),
  .pinOe     (pinOe),
  .irqOut    (irqOut),
  .softRstQ  (softRstQ),
  .statusVec (statusVec),
  .maskVec   (maskVec)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;

  localparam int PINS = 12;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] FULL = (32'd1 << PINS) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut;
  logic [PINS-1:0] pinOe;
  logic        irqOut;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.PINS(PINS)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] addr, input logic [31:0] data);
    regAddr = addr;
    wrData  = data;
    wrEn    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] addr, output logic [31:0] data);
    regAddr = addr;
    #1;
    data = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic softReset();
    regWrite(6'h3C, 32'h1);
    regWrite(6'h3C, 32'h0);
  endtask

  function automatic logic [31:0] modeWord(input int pin, input int code, input int word);
    logic [31:0] w = '0;
    for (int n = 8*word; n < 8*word + 8; n++) begin
      if (n < PINS) w[4*(n-8*word) +: 3] = (n == pin) ? 3'(code) : 3'd7;
    end
    return w;
  endfunction

  logic [31:0] rv;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(6'h00, rv); checkEq("R1", "enable reset", rv, 0);
    regRead(6'h04, rv); checkEq("R1", "status reset", rv, 0);
    regRead(6'h08, rv); checkEq("R1", "display reset", rv, 0);
    regRead(6'h10, rv); checkEq("R1", "mask reset", rv, FULL);
    regRead(6'h14, rv); checkEq("R1", "mask alias reset", rv, FULL);
    regRead(6'h20, rv); checkEq("R1", "dir reset", rv, 0);
    regRead(6'h24, rv); checkEq("R1", "mode0 reset", rv, 0);
    regRead(6'h3C, rv); checkEq("R1", "srst reset", rv, 0);
    checkEq("R1", "irq reset", {31'd0, irqOut}, 0);
    checkEq("R3", "pinOe reset", {20'd0, pinOe}, 0);

    // R2 upper bits ignored
    regWrite(6'h00, 32'hFFFF_FFFF);
    regRead(6'h00, rv); checkEq("R2", "enable width", rv, FULL);
    regWrite(6'h00, 32'h0);

    // R3 direction and output
    regWrite(6'h18, 32'h0000_0A5A);
    regWrite(6'h20, 32'h0000_00F0);
    checkEq("R3", "pinOut", {20'd0, pinOut}, 32'hA5A);
    checkEq("R3", "pinOe", {20'd0, pinOe}, 32'h0F0);
    regWrite(6'h20, 32'hFFFF_FFFF);
    checkEq("R3", "pinOe all", {20'd0, pinOe}, FULL);

    // R4 input synchronizer latency, read-only registers
    pinIn = 12'h3C5;
    @(posedge clk); @(negedge clk);
    regRead(6'h1C, rv); checkEq("R4", "input after one edge", rv, 0);
    @(posedge clk); @(negedge clk);
    regRead(6'h1C, rv); checkEq("R4", "input after two edges", rv, 32'h3C5);
    regWrite(6'h1C, 32'h0);
    regRead(6'h1C, rv); checkEq("R4", "input write ignored", rv, 32'h3C5);
    regWrite(6'h04, FULL);
    regRead(6'h04, rv); checkEq("R4", "status write ignored", rv, 0);
    pinIn = '0;
    idle(3);

    // R5 mode field layout
    regWrite(6'h24, 32'hFFFF_FFFF);
    regWrite(6'h28, 32'hFFFF_FFFF);
    regRead(6'h24, rv); checkEq("R5", "mode0 layout", rv, 32'h7777_7777);
    regRead(6'h28, rv); checkEq("R5", "mode1 layout", rv, 32'h0000_7777);

    // R12 function select, reserved words
    regWrite(6'h38, 32'hFFFF_FABC);
    regRead(6'h38, rv); checkEq("R12", "function select", rv, 32'hABC);
    checkEq("R12", "no pin effect", {20'd0, pinOut}, 32'hA5A);
    regWrite(6'h30, 32'hFFFF_FFFF);
    regRead(6'h30, rv); checkEq("R1", "reserved reads zero", rv, 0);

    // R11 soft reset
    regWrite(6'h3C, 32'h1);
    regRead(6'h3C, rv); checkEq("R11", "srst readback", rv, 1);
    regWrite(6'h00, FULL);
    regRead(6'h00, rv); checkEq("R11", "write held off", rv, 0);
    regWrite(6'h3C, 32'h0);
    regRead(6'h10, rv); checkEq("R11", "mask restored", rv, FULL);
    regRead(6'h24, rv); checkEq("R11", "mode restored", rv, 0);
    regRead(6'h38, rv); checkEq("R11", "func restored", rv, 0);
    checkEq("R11", "pinOe restored", {20'd0, pinOe}, 0);

    // R8 mask set and clear
    regWrite(6'h14, FULL);
    regRead(6'h10, rv); checkEq("R8", "unmask all", rv, 0);
    regWrite(6'h10, 32'h005);
    regRead(6'h10, rv); checkEq("R8", "mask set", rv, 32'h005);
    regWrite(6'h10, 32'h000);
    regRead(6'h10, rv); checkEq("R8", "zero set no effect", rv, 32'h005);
    regWrite(6'h14, 32'h001);
    regRead(6'h10, rv); checkEq("R8", "mask clear", rv, 32'h004);

    // R6 enable gating, R10 display and irq with level-high on pin 2
    regWrite(6'h24, modeWord(2, 3, 0));
    regWrite(6'h28, modeWord(2, 3, 1));
    pinIn = 12'h004;
    idle(4);
    regRead(6'h04, rv); checkEq("R6", "disabled no status", rv, 0);
    regWrite(6'h00, FULL);
    idle(1);
    regRead(6'h04, rv); checkEq("R6", "enabled level high", rv, 32'h004);
    regRead(6'h08, rv); checkEq("R10", "masked display", rv, 0);
    checkEq("R10", "masked irq", {31'd0, irqOut}, 0);
    regWrite(6'h14, 32'h004);
    regRead(6'h08, rv); checkEq("R10", "unmasked display", rv, 32'h004);
    checkEq("R10", "unmasked irq", {31'd0, irqOut}, 1);
    regWrite(6'h0C, 32'h004);
    regRead(6'h04, rv); checkEq("R7", "set wins over clear", rv, 32'h004);
    pinIn = '0;
    idle(4);
    regWrite(6'h0C, 32'h000);
    regRead(6'h04, rv); checkEq("R9", "zero clear no effect", rv, 32'h004);
    regWrite(6'h0C, 32'h004);
    regRead(6'h04, rv); checkEq("R9", "clear status", rv, 0);
    checkEq("R10", "irq drops", {31'd0, irqOut}, 0);

    // R5 R6 R7 R9 sweep: every pin against every mode code
    for (int p = 0; p < PINS; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] bitP;
        bitP = 32'd1 << p;
        softReset();
        regWrite(6'h24, modeWord(p, m, 0));
        regWrite(6'h28, modeWord(p, m, 1));
        regWrite(6'h00, FULL);
        pinIn = '0;
        idle(4);
        regWrite(6'h0C, FULL);
        regRead(6'h04, rv);
        checkEq("R7", $sformatf("pin %0d mode %0d low after clear", p, m),
                rv, (m == 2) ? bitP : 0);
        pinIn = 12'(bitP);
        idle(4);
        regRead(6'h04, rv);
        checkEq("R5", $sformatf("pin %0d mode %0d after rise", p, m),
                rv, (m >= 1 && m <= 4) ? bitP : 0);
        regWrite(6'h0C, FULL);
        regRead(6'h04, rv);
        checkEq("R9", $sformatf("pin %0d mode %0d high after clear", p, m),
                rv, (m == 3) ? bitP : 0);
        pinIn = '0;
        idle(4);
        regRead(6'h04, rv);
        checkEq("R6", $sformatf("pin %0d mode %0d after fall", p, m),
                rv, (m == 0 || m == 2 || m == 3 || m == 4) ? bitP : 0);
        regWrite(6'h0C, FULL);
        regRead(6'h04, rv);
        checkEq("R6", $sformatf("pin %0d mode %0d low final clear", p, m),
                rv, (m == 2) ? bitP : 0);
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule